// File: doc/BRIEF.md
# OSD Dot Colour, Shadow and Blink Stage

This stage sits at the end of an on-screen-display pipeline. Each dot clock it gets one font bit for the dot being painted, the attributes of the character and word that bit belongs to, and the frame-wide settings. From these it produces the red, green and blue overlay outputs and the fast-blanking output that switches the video path over to the overlay. Characters carry their own 3-bit foreground colour and a blink flag. Words carry a 3-bit background colour. A frame-wide background mode decides where that background colour appears: nowhere, over the whole character box, as a shadow on the lower-right side of lit dots, or over the whole raster with the blanking forced on.

Blinking is timed by a free-running 7-bit count of frame ticks. A blinking character loses its lit dots during the off phase. The blink period is 64 or 128 frames, and the on:off ratio is 1:1, 1:3 or 3:1. Each of the four outputs has its own polarity bit. All outputs are registered, and they sit at their inactive level while the display is disabled.

Top module: `osd_pixel_colorizer`

## Requirements
- R1: All four outputs are registered. A dot presented on the inputs at one rising clock edge appears on the outputs after that edge. While reset is active, every output reads 0.
- R2: The effective dot is font_dot with its lit state removed during a blink-off phase (see R7). Inside the window (active=1), a lit effective dot drives {R,G,B} = fg_rgb[2], fg_rgb[1], fg_rgb[0] and sets fast blanking in every background mode.
- R3: In mode 0 (no background), an unlit dot drives all four outputs inactive. In modes 0, 1 and 2, every dot outside the window drives all four outputs inactive.
- R4: In mode 1 (box), an unlit dot inside the window drives bg_rgb (same bit order as R2) and sets fast blanking.
- R5: In mode 2 (north-west shadow), an unlit dot at column x drives bg_rgb and sets fast blanking only when two dots are both lit: the effective dot at column x-1 on the same line, and the effective dot at column x-1 on the previous windowed line. Any other unlit dot is inactive. Column 0 has no neighbour. The first line after a frame tick has no previous line.
- R6: In mode 3 (frame), fast blanking is set on every dot while the display is enabled, inside or outside the window. Unlit dots inside the window drive bg_rgb. RGB is inactive outside the window.
- R7: A 7-bit counter starts at 0 at reset and increments on each frame_tick. The phase q is counter bits [5:4] when blink_slow=0 (64-frame period) and bits [6:5] when blink_slow=1 (128-frame period). blink_ratio selects the off condition: 0 gives 1:1 (off when q>=2), 1 gives 1:3 (off when q!=0), 2 gives 3:1 (off when q==3), and 3 never blinks off. During an off phase, a character with blink_en=1 is treated as unlit. This also applies to the shadow neighbours of R5.
- R8: Each output is XORed with its own polarity bit before the output register: out_pol[0] for R, [1] for G, [2] for B, [3] for fast blanking.
- R9: With disp_en=0, each output equals its polarity bit, which is its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_en | input | 1 | Display enable |
| frame_tick | input | 1 | One-cycle pulse per vertical sync |
| active | input | 1 | Display window for the current dot |
| dot_x | input | XW | Column of the current dot within the line |
| font_dot | input | 1 | Font bit for the current dot |
| fg_rgb | input | 3 | Character foreground colour, bits R,G,B from MSB |
| blink_en | input | 1 | Character blinks |
| bg_rgb | input | 3 | Word background colour, bits R,G,B from MSB |
| bg_mode | input | 2 | 0 none, 1 box, 2 north-west shadow, 3 frame |
| blink_ratio | input | 2 | 0 1:1, 1 1:3, 2 3:1, 3 no blink |
| blink_slow | input | 1 | 0: 64-frame period, 1: 128-frame period |
| out_pol | input | 4 | Polarity per output: [0] R, [1] G, [2] B, [3] FB |
| r_o | output | 1 | Red overlay |
| g_o | output | 1 | Green overlay |
| b_o | output | 1 | Blue overlay |
| fb_o | output | 1 | Fast blanking |

## Verification
The bench builds the block with LINE_DOTS=8, so a line is eight dots and the whole previous-line store is small. With lines that short, every background mode can be crossed with several polarity patterns over several multi-line frames of pseudo-random font and attribute data. The short lines also leave room for a run of full 128-frame blink cycles under each ratio and period. That sweep reaches every shadow-neighbour combination, including column 0 and the first line of a frame. It also reaches every phase boundary of the frame counter, wrap-around included.

// File: rtl/osd_pixel_colorizer.sv
module osd_pixel_colorizer #(
  parameter int LINE_DOTS = 64,
  localparam int XW = (LINE_DOTS > 1) ? $clog2(LINE_DOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_en,
  input  logic          frame_tick,
  input  logic          active,
  input  logic [XW-1:0] dot_x,
  input  logic          font_dot,
  input  logic [2:0]    fg_rgb,
  input  logic          blink_en,
  input  logic [2:0]    bg_rgb,
  input  logic [1:0]    bg_mode,
  input  logic [1:0]    blink_ratio,
  input  logic          blink_slow,
  input  logic [3:0]    out_pol,
  output logic          r_o,
  output logic          g_o,
  output logic          b_o,
  output logic          fb_o
);

  logic [6:0]           frame_cnt;
  logic [1:0]           phase;
  logic                 blink_off;
  logic                 eff;
  logic [LINE_DOTS-1:0] line_bits;
  logic                 left_q, upleft_q;
  logic                 shadow;
  logic [2:0]           rgb;
  logic                 fb;
  logic [3:0]           next_out;

  assign phase = blink_slow ? frame_cnt[6:5] : frame_cnt[5:4];

  always_comb begin
    unique case (blink_ratio)
      2'd0:    blink_off = phase[1];
      2'd1:    blink_off = (phase != 2'd0);
      2'd2:    blink_off = (phase == 2'd3);
      default: blink_off = 1'b0;
    endcase
  end

  assign eff    = font_dot & ~(blink_en & blink_off);
  assign shadow = ~eff & left_q & upleft_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      line_bits <= '0;
      left_q    <= 1'b0;
      upleft_q  <= 1'b0;
    end else begin
      if (frame_tick) frame_cnt <= frame_cnt + 7'd1;
      if (frame_tick) line_bits <= '0;
      else if (active) line_bits[dot_x] <= eff;
      left_q   <= active & eff;
      upleft_q <= active & line_bits[dot_x];
    end
  end

  always_comb begin
    rgb = 3'b000;
    fb  = (bg_mode == 2'd3);
    if (active) begin
      if (eff) begin
        rgb = fg_rgb;
        fb  = 1'b1;
      end else if (bg_mode == 2'd1 || bg_mode == 2'd3 ||
                   (bg_mode == 2'd2 && shadow)) begin
        rgb = bg_rgb;
        fb  = 1'b1;
      end
    end
  end

  assign next_out = disp_en ? ({fb, rgb[0], rgb[1], rgb[2]} ^ out_pol) : out_pol;

  always_ff @(posedge clk) begin
    if (!rst_n) {fb_o, b_o, g_o, r_o} <= 4'b0000;
    else        {fb_o, b_o, g_o, r_o} <= next_out;
  end

endmodule

module osd_pixel_colorizer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       disp_en,
  input logic       active,
  input logic       font_dot,
  input logic       blink_en,
  input logic [2:0] fg_rgb,
  input logic [2:0] bg_rgb,
  input logic [1:0] bg_mode,
  input logic [3:0] out_pol,
  input logic       r_o,
  input logic       g_o,
  input logic       b_o,
  input logic       fb_o
);
  a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> ({fb_o, b_o, g_o, r_o} == $past(out_pol)));

  a_r6_frame_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && bg_mode == 2'd3) |=> (fb_o != $past(out_pol[3])));

  a_r3_outside_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !active && bg_mode != 2'd3) |=> ({fb_o, b_o, g_o, r_o} == $past(out_pol)));

  a_r2_foreground: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && active && font_dot && !blink_en) |=>
      ({fb_o, b_o, g_o, r_o} == ({1'b1, $past(fg_rgb[0]), $past(fg_rgb[1]), $past(fg_rgb[2])} ^ $past(out_pol))));

  a_r4_box_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && active && !font_dot && bg_mode == 2'd1) |=>
      ({fb_o, b_o, g_o, r_o} == ({1'b1, $past(bg_rgb[0]), $past(bg_rgb[1]), $past(bg_rgb[2])} ^ $past(out_pol))));
endmodule

bind osd_pixel_colorizer osd_pixel_colorizer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .active(active),
  .font_dot(font_dot), .blink_en(blink_en), .fg_rgb(fg_rgb), .bg_rgb(bg_rgb),
  .bg_mode(bg_mode), .out_pol(out_pol),
  .r_o(r_o), .g_o(g_o), .b_o(b_o), .fb_o(fb_o)
);

// File: tb/osd_pixel_colorizer_tb.sv
module osd_pixel_colorizer_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, disp_en, frame_tick, active, font_dot, blink_en, blink_slow;
  logic [2:0] dot_x;
  logic [2:0] fg_rgb, bg_rgb;
  logic [1:0] bg_mode, blink_ratio;
  logic [3:0] out_pol;
  logic       r_o, g_o, b_o, fb_o;

  osd_pixel_colorizer #(.LINE_DOTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .frame_tick(frame_tick),
    .active(active), .dot_x(dot_x), .font_dot(font_dot), .fg_rgb(fg_rgb),
    .blink_en(blink_en), .bg_rgb(bg_rgb), .bg_mode(bg_mode),
    .blink_ratio(blink_ratio), .blink_slow(blink_slow), .out_pol(out_pol),
    .r_o(r_o), .g_o(g_o), .b_o(b_o), .fb_o(fb_o)
  );

  int checks = 0;
  int fails  = 0;
  logic [6:0]  m_cnt = '0;
  bit          m_prev [N];
  bit          m_cur  [N];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic boff(input logic [6:0] c, input logic [1:0] ra, input logic sl);
    logic [1:0] q;
    q = sl ? c[6:5] : c[5:4];
    case (ra)
      2'd0: return q >= 2'd2;
      2'd1: return q != 2'd0;
      2'd2: return q == 2'd3;
      default: return 1'b0;
    endcase
  endfunction

  task automatic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got {fb,b,g,r}=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic step();
    logic off, eff, sh;
    logic [2:0] rgb;
    logic fb;
    logic [3:0] exp;
    string tag;
    int x;
    x   = int'(dot_x);
    off = boff(m_cnt, blink_ratio, blink_slow);
    eff = font_dot && !(blink_en && off);
    sh  = active && !eff && x > 0 && m_cur[x-1] && m_prev[x-1];
    rgb = 3'b000;
    fb  = (bg_mode == 2'd3);
    if (active && eff) begin rgb = fg_rgb; fb = 1'b1; end
    else if (active && (bg_mode == 2'd1 || bg_mode == 2'd3 || (bg_mode == 2'd2 && sh))) begin
      rgb = bg_rgb; fb = 1'b1;
    end
    exp = disp_en ? ({fb, rgb[0], rgb[1], rgb[2]} ^ out_pol) : out_pol;
    if (!disp_en) tag = "R9";
    else if (active && font_dot && blink_en && off) tag = "R7";
    else if (active && eff) tag = "R2";
    else if (bg_mode == 2'd3) tag = "R6";
    else if (!active) tag = "R3";
    else if (bg_mode == 2'd2) tag = "R5";
    else if (bg_mode == 2'd1) tag = "R4";
    else tag = "R3";
    if (out_pol != 4'd0) tag = {tag, "/R8"};
    @(posedge clk);
    if (frame_tick) begin
      m_cnt++;
      foreach (m_prev[i]) begin m_prev[i] = 0; m_cur[i] = 0; end
    end else if (active) m_cur[x] = eff;
    @(negedge clk);
    check(tag, {fb_o, b_o, g_o, r_o}, exp);
  endtask

  task automatic run_line();
    foreach (m_cur[i]) begin m_prev[i] = m_cur[i]; m_cur[i] = 0; end
    active = 1'b0; font_dot = 1'b0; frame_tick = 1'b0;
    step();
    for (int x = 0; x < N; x++) begin
      rnd();
      active   = 1'b1;
      dot_x    = 3'(x);
      font_dot = lfsr[0] | lfsr[5];
      fg_rgb   = lfsr[3:1];
      blink_en = lfsr[4] & lfsr[7];
      if (x % 4 == 0) bg_rgb = lfsr[10:8];
      step();
    end
    active = 1'b0;
  endtask

  task automatic run_frame(input int lines);
    active = 1'b0; font_dot = 1'b0; frame_tick = 1'b1;
    step();
    frame_tick = 1'b0;
    for (int l = 0; l < lines; l++) run_line();
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; disp_en = 1'b0; frame_tick = 1'b0; active = 1'b0; dot_x = '0;
    font_dot = 1'b0; fg_rgb = '0; bg_rgb = '0; blink_en = 1'b0; bg_mode = '0;
    blink_ratio = 2'd3; blink_slow = 1'b0; out_pol = 4'hF; disp_en = 1'b1; font_dot = 1'b1;
    active = 1'b1; fg_rgb = 3'd5;
    repeat (3) @(negedge clk);
    check("R1 reset", {fb_o, b_o, g_o, r_o}, 4'b0000);
    active = 1'b0; font_dot = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R9: disabled display under several polarity settings
    disp_en = 1'b0;
    for (int p = 0; p < 16; p++) begin
      out_pol = 4'(p); active = p[0]; font_dot = 1'b1; bg_mode = 2'(p);
      step();
    end
    disp_en = 1'b1;

    // R2..R6, R8: every mode crossed with polarity patterns
    blink_ratio = 2'd3;
    for (int m = 0; m < 4; m++) begin
      for (int pi = 0; pi < 3; pi++) begin
        bg_mode = 2'(m);
        out_pol = (pi == 0) ? 4'h0 : (pi == 1) ? 4'hF : 4'h5;
        for (int f = 0; f < 3; f++) run_frame(4);
      end
    end

    // R7: full blink cycles per ratio and period, shadow mode keeps R5 active
    out_pol = 4'h0; bg_mode = 2'd2;
    for (int ra = 0; ra < 4; ra++) begin
      for (int sl = 0; sl < 2; sl++) begin
        blink_ratio = 2'(ra); blink_slow = sl[0];
        for (int f = 0; f < 128; f++) run_frame(2);
      end
    end

    // R9 again mid-stream, then R1 reset value
    disp_en = 1'b0; out_pol = 4'hA;
    run_line();
    disp_en = 1'b1;
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 reset", {fb_o, b_o, g_o, r_o}, 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule